// File: doc/BRIEF.md
# CAN bus wake-up pattern detector

This block sits beside a CAN transceiver's mode logic and watches a sampled bus-dominant bit while the transceiver is in its low-power state. It raises a sticky wake request only when the bus shows a dominant phase, then a recessive phase, then a second dominant phase. Each phase must survive a digital filter, and the whole sequence must fit inside a bounded window. Noise, short spikes and a bus clamped dominant for a long time never produce a request.

The bus bit first passes a two-flop synchronizer. A run-length filter then turns it into a qualified level. A small sequencer tracks the pattern and the window. The filter time and the window length are parameters in clock cycles. The default `FILT_CYC` of 38 is 3.8 µs at a 10 MHz clock, and the default `WAKE_CYC` is 10000. The mode logic enables the detector in standby and drops the enable to clear a pending request. An undervoltage flag stops the pattern from being recognised.

Top module: `cwake_detect`

## Requirements
- R1: After reset, `wake_req_o` is 0 and `dbg_state_o` is 0.
- R2: The bus level is synchronised through two flops. The qualified level changes only after the new level has been present on `bus_dom_i` at `FILT_CYC` consecutive rising clock edges, so a phase of exactly `FILT_CYC` cycles qualifies.
- R3: A dominant or recessive phase shorter than `FILT_CYC` cycles is ignored and does not advance the pattern, including a short recessive gap inside a dominant phase.
- R4: A qualified dominant phase, then a qualified recessive phase, then a qualified dominant phase sets `wake_req_o`. The flag is visible after the clock edge `FILT_CYC+2` edges past the first edge that samples the second dominant. The pattern state only advances from idle to the first-dominant state.
- R5: The onset of the second dominant phase must be at most `WAKE_CYC` cycles after the onset of the first. Otherwise the pattern returns to idle and must be seen again in full. When completion and expiry fall in the same cycle, completion wins.
- R6: One continuous dominant phase of any length never sets `wake_req_o`.
- R7: While `uv_i` is 1, the pattern is held in idle and no new wake request is set. A request already set stays set.
- R8: When `det_en_i` is 0 at a clock edge, both `wake_req_o` and the pattern state are 0 after that edge.
- R9: Once set, `wake_req_o` stays 1 for as long as `det_en_i` stays 1, whatever the bus does.
- R10: `dbg_state_o` encodes the pattern state: 0 = idle, 1 = first dominant seen, 2 = recessive gap seen, 3 = wake requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_en_i | input | 1 | Detector enable from the mode logic (standby) |
| uv_i | input | 1 | Supply undervoltage flag |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| wake_req_o | output | 1 | Sticky wake request |
| dbg_state_o | output | 2 | Pattern state for debug |

## Verification
The expiry of the window and the qualification of the second dominant phase can fall in the same cycle. The bench provokes this by spacing the two dominant onsets exactly `WAKE_CYC` cycles apart, which must wake the detector, and then `WAKE_CYC+1` cycles apart, which must not. A behavioural reference model built from run lengths and a sample queue is compared with both outputs on every cycle. Exact-threshold phases of `FILT_CYC` and `FILT_CYC-1` cycles, a long dominant clamp, and undervoltage applied before and after a wake are judged the same way.

// File: rtl/cwake_pkg.sv
package cwake_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'd0,
    ST_DOM1 = 2'd1,
    ST_GAP  = 2'd2,
    ST_WOKE = 2'd3
  } wstate_e;
endpackage

// File: rtl/cwake_sync.sv
module cwake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cwake_filter.sv
module cwake_filter #(
  parameter int unsigned FILT_CYC = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q, rise_q, fall_q;

  // level flips only after FILT_CYC samples that disagree with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (s_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        lvl_q  <= s_i;
        rise_q <= s_i;
        fall_q <= ~s_i;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/cwake_seq.sv
module cwake_seq
  import cwake_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 10000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    uv_i,
  input  logic    rise_i,
  input  logic    fall_i,
  output wstate_e state_o
);
  localparam int unsigned WW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
  localparam logic [WW-1:0] W_LAST = WW'(WAKE_CYC - 1);

  wstate_e       state_q, state_d;
  logic [WW-1:0] w_q, w_d;
  logic          last;

  assign last = (w_q == W_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!uv_i && rise_i) state_d = ST_DOM1;
      ST_DOM1: begin
        if (uv_i || last) state_d = ST_IDLE;
        else if (fall_i)  state_d = ST_GAP;
      end
      ST_GAP: begin
        // completion beats expiry in the last window cycle
        if (uv_i)        state_d = ST_IDLE;
        else if (rise_i) state_d = ST_WOKE;
        else if (last)   state_d = ST_IDLE;
      end
      ST_WOKE: state_d = ST_WOKE;
      default: state_d = ST_IDLE;
    endcase
    if (!en_i) state_d = ST_IDLE;
  end

  always_comb begin
    if (en_i && (state_q == ST_DOM1 || state_q == ST_GAP)) w_d = w_q + WW'(1);
    else                                                    w_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      w_q     <= '0;
    end else begin
      state_q <= state_d;
      w_q     <= w_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/cwake_detect.sv
module cwake_detect
  import cwake_pkg::*;
#(
  parameter int unsigned FILT_CYC    = 38,
  parameter int unsigned WAKE_CYC    = 10000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            det_en_i,
  input  logic            uv_i,
  input  logic            bus_dom_i,
  output logic            wake_req_o,
  output logic [ST_W-1:0] dbg_state_o
);
  logic    bus_s, lvl, rise, fall;
  wstate_e state;

  cwake_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_dom_i),
    .q_o   (bus_s)
  );

  cwake_filter #(.FILT_CYC(FILT_CYC)) i_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (bus_s),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  cwake_seq #(.WAKE_CYC(WAKE_CYC)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (det_en_i),
    .uv_i   (uv_i),
    .rise_i (rise),
    .fall_i (fall & ~lvl),
    .state_o(state)
  );

  assign wake_req_o  = (state == ST_WOKE);
  assign dbg_state_o = state;
endmodule

// File: rtl/cwake_detect_chk.sv
module cwake_detect_chk #(
  parameter int unsigned WAKE_CYC = 10000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       det_en_i,
  input logic       uv_i,
  input logic       wake_req_o,
  input logic [1:0] dbg_state_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 2);

  logic [CW-1:0] in_pat_cnt;
  logic          in_pat;

  assign in_pat = (dbg_state_o == 2'd1) || (dbg_state_o == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     in_pat_cnt <= '0;
    else if (in_pat) in_pat_cnt <= in_pat_cnt + CW'(1);
    else             in_pat_cnt <= '0;
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> (!wake_req_o && dbg_state_o == 2'd0));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_req_o && det_en_i) |=> wake_req_o);

  p_uv_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_req_o && uv_i) |=> !wake_req_o);

  p_wake_from_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_req_o) |-> ($past(dbg_state_o) == 2'd2));

  p_idle_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_state_o == 2'd0) |=> (dbg_state_o <= 2'd1));

  p_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pat |-> (32'(in_pat_cnt) < WAKE_CYC));
endmodule

bind cwake_detect cwake_detect_chk #(.WAKE_CYC(WAKE_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .det_en_i   (det_en_i),
  .uv_i       (uv_i),
  .wake_req_o (wake_req_o),
  .dbg_state_o(dbg_state_o)
);

// File: tb/test_cwake_detect.sv
module test_cwake_detect;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int WAKE = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       uv = 1'b0;
  logic       bus = 1'b0;
  logic       wake;
  logic [1:0] dbg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwake_detect #(.FILT_CYC(FILT), .WAKE_CYC(WAKE)) i_cwake_detect (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .det_en_i   (en),
    .uv_i       (uv),
    .bus_dom_i  (bus),
    .wake_req_o (wake),
    .dbg_state_o(dbg)
  );

  // reference model: sample queue, run length, pattern age
  bit hist[$];
  int m_lvl, m_run, m_rise, m_fall, m_st, m_age, synced;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      m_lvl = 0; m_run = 0; m_rise = 0; m_fall = 0; m_st = 0; m_age = 0;
    end else begin
      if (!en) begin
        m_st = 0; m_age = 0;
      end else begin
        case (m_st)
          0: if (!uv && m_rise == 1) begin m_st = 1; m_age = 0; end
          1: begin
            if (uv || m_age == WAKE-1) m_st = 0;
            else begin
              if (m_fall == 1) m_st = 2;
              m_age++;
            end
          end
          2: begin
            if (uv) m_st = 0;
            else if (m_rise == 1) m_st = 3;
            else if (m_age == WAKE-1) m_st = 0;
            else m_age++;
          end
          default: ;
        endcase
      end
      synced = int'(hist[0]);
      m_rise = 0; m_fall = 0;
      if (synced == m_lvl) m_run = 0;
      else begin
        m_run++;
        if (m_run == FILT) begin
          m_lvl = synced; m_run = 0;
          if (synced == 1) m_rise = 1; else m_fall = 1;
        end
      end
      hist.push_back(bus);
      void'(hist.pop_front());
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(wake) == (m_st == 3 ? 1 : 0), "R4 model wake", int'(wake), (m_st == 3) ? 1 : 0);
      chk(int'(dbg) == m_st, "R10 model state", int'(dbg), m_st);
    end
  end

  task automatic drive(input bit lvl, input int n);
    bus = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input int ew, input int es, input string req);
    chk(int'(wake) == ew, req, int'(wake), ew);
    chk(int'(dbg) == es, req, int'(dbg), es);
  endtask

  task automatic clear_req;
    en = 1'b0;
    @(negedge clk);
    expect_out(0, 0, "R8 enable low clears");
    en = 1'b1;
  endtask

  task automatic summary;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog all requirements act=hung exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out(0, 0, "R1 reset state");
    rst_n = 1'b1;
    en = 1'b1;
    drive(0, 5);
    expect_out(0, 0, "R1 after release");

    // R3: spikes shorter than the filter
    for (int i = 0; i < 6; i++) begin drive(1, FILT-1); drive(0, FILT-1); end
    drive(0, 10);
    expect_out(0, 0, "R3 short spikes ignored");
    // R3: short recessive gap inside a dominant phase
    drive(1, 8); drive(0, FILT-1); drive(1, 8); drive(0, 60);
    expect_out(0, 0, "R3 short gap ignored");

    // R2/R4: exact-threshold pattern wakes
    drive(1, FILT); drive(0, FILT); drive(1, FILT);
    drive(0, FILT+1);
    expect_out(1, 3, "R4 threshold pattern wakes");
    chk(int'(dbg) == 3, "R10 woken code", int'(dbg), 3);
    // R9: sticky under bus activity
    drive(1, 50); drive(0, 30);
    expect_out(1, 3, "R9 flag sticky");
    clear_req();

    // R2: first dominant one cycle short does not qualify
    drive(1, FILT-1); drive(0, FILT); drive(1, FILT); drive(0, 60);
    expect_out(0, 0, "R2 short first dominant");

    // R6: long clamp
    drive(1, 300);
    expect_out(0, 0, "R6 long dominant no wake");
    drive(0, 10); drive(1, FILT); drive(0, 60);
    expect_out(0, 0, "R6 after clamp");

    // R5: onsets exactly WAKE apart wake (completion wins tie)
    drive(1, 20); drive(0, WAKE-20); drive(1, 10); drive(0, 10);
    expect_out(1, 3, "R5 window edge wakes");
    clear_req();
    drive(0, 60);
    // R5: one cycle late, full pattern required again
    drive(1, 20); drive(0, WAKE-19); drive(1, 10); drive(0, 60);
    expect_out(0, 0, "R5 one cycle late no wake");

    // R7: undervoltage blocks a valid pattern
    uv = 1'b1;
    drive(1, FILT); drive(0, FILT); drive(1, FILT); drive(0, 20);
    expect_out(0, 0, "R7 uv blocks pattern");
    uv = 1'b0;
    drive(0, 60);
    // R7: undervoltage drops a pattern in progress
    drive(1, 10);
    chk(int'(dbg) == 1, "R7 first dominant seen", int'(dbg), 1);
    uv = 1'b1;
    @(negedge clk);
    uv = 1'b0;
    expect_out(0, 0, "R7 uv resets pattern");
    drive(0, 60);
    // R7: uv after wake keeps the flag
    drive(1, FILT); drive(0, FILT); drive(1, FILT); drive(0, 10);
    expect_out(1, 3, "R7 wake before uv");
    uv = 1'b1;
    drive(0, 10);
    expect_out(1, 3, "R7 uv keeps flag");
    uv = 1'b0;
    clear_req();
    drive(0, 5);
    expect_out(0, 0, "R8 stays clear");
    summary();
  end
endmodule